// File: doc/BRIEF.md
# Multi-Stage Watchdog Timer with Key-Locked Configuration

This block is a watchdog that escalates through a fixed number of timeout stages. A programmable divider turns the core clock into a slow tick. A single stage counter counts ticks against the timeout value of the current stage. When a stage runs out, the block performs that stage's configured action and moves on to the next stage. The action can be nothing, raising an interrupt, pulsing the CPU reset or pulsing the system reset. Software keeps the watchdog quiet by feeding it, which sends the sequence back to stage 0.

All configuration sits behind a key. A register write only takes effect while the key register holds one fixed 32-bit value, and writing any other value to the key locks the block again. The register port is a plain synchronous write strobe with a combinational read. It has no valid/ready handshake and never applies back-pressure: every write strobe completes in the cycle it is sampled. Interrupt and reset outputs are plain level or pulse pins.

Top module: `wdt_multistage`

## Requirements
- R1: A write to any address other than KEY (address 7) is ignored unless the key register holds 32'hA5C3_0F69. Writing any other value to KEY locks the block again. Reads are never blocked, and reading KEY returns the unlock state in bit 0.
- R2: While unlocked, a write of any data to FEED (address 6) returns the sequence to stage 0 and clears both the tick divider and the stage count.
- R3: The tick period is DIV (address 1) clocks, and a DIV of 0 counts as 1. Stage i expires on its TMO_i-th tick (addresses 2 to 5), and a TMO of 0 counts as 1. After a feed or enable at clock edge F, stage 0 expires at edge F + TMO_0*DIV.
- R4: Stage i's action sits in CTRL bits [10+2i:9+2i], with 0 = off, 1 = interrupt, 2 = CPU reset and 3 = system reset. A stage that expires with a non-off action performs that action and moves to the next stage, which starts counting again from zero.
- R5: The sequence halts in two cases: a stage with action off expires, or the last stage expires. A halted block takes no further action and holds its stage until it is fed or disabled. STAT (address 11) reads the stage in bits [1:0] and the halted flag in bit 2.
- R6: A reset action drives its pulse output high starting in the cycle after the expiring edge. The pulse lasts 2^(code+1) clocks, where the code is CTRL[5:3] for the CPU reset and CTRL[8:6] for the system reset. Code 7 gives 256 clocks.
- R7: The raw interrupt status (IRAW, address 8, bit 0) sets when an interrupt-action stage expires. It stays set until a 1 is written to bit 0 of ICLR (address 10). If a set and a clear land in the same cycle, the set wins.
- R8: The level interrupt output equals raw status AND IENA bit 0 (address 9) AND CTRL bit 1.
- R9: If IENA bit 0 and CTRL bit 2 are both set, the edge interrupt output gives a one-clock pulse in the cycle after an interrupt expiry. This happens whether or not the level output is enabled.
- R10: While CTRL bit 0 (enable) is clear, the divider, stage and count are held at zero and no action fires. Setting the enable bit starts stage 0 with a full tick period.
- R11: After reset all registers read zero, the block is locked and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_level_o | output | 1 | Level interrupt, held until cleared |
| irq_edge_o | output | 1 | One-clock interrupt pulse |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The escalation path is driven with several patterns:
- An interrupt stage followed by a system-reset stage checks the exact expiry cycles and the pulse width.
- A feed in the middle of a stage confirms that the expiry moves with the feed and does not stay on the original schedule.
- A feed issued while locked must leave the schedule untouched.
- A stage whose action is off must halt the sequence silently.

Divider values of 0 and 1, a timeout of 0 and the longest reset code cover the boundaries. The edge-only and masked-level runs separate the two interrupt outputs from the raw status.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_STG = 4;
  localparam int ACT_W   = 2;
  localparam int CODE_W  = 3;
  localparam int SIDX_W  = $clog2(NUM_STG);

  typedef enum logic [ACT_W-1:0] {
    ACT_OFF = 2'd0,
    ACT_IRQ = 2'd1,
    ACT_CPU = 2'd2,
    ACT_SYS = 2'd3
  } act_e;

  // register word addresses
  localparam int A_CTRL = 0;
  localparam int A_DIV  = 1;
  localparam int A_TMO0 = 2;
  localparam int A_FEED = 6;
  localparam int A_KEY  = 7;
  localparam int A_IRAW = 8;
  localparam int A_IENA = 9;
  localparam int A_ICLR = 10;
  localparam int A_STAT = 11;

  // control word layout
  localparam int C_EN     = 0;
  localparam int C_LVL    = 1;
  localparam int C_EDGE   = 2;
  localparam int C_CPU_LO = 3;
  localparam int C_SYS_LO = C_CPU_LO + CODE_W;
  localparam int C_ACT_LO = C_SYS_LO + CODE_W;
  localparam int CTRL_W   = C_ACT_LO + ACT_W * NUM_STG;

  localparam logic [31:0] UNLOCK_KEY = 32'hA5C3_0F69;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_cnt;
  logic [DIV_W-1:0] last_val;

  assign last_val = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick     = en && (pre_cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_cnt <= '0;
    else if (!en || clr)      pre_cnt <= '0;
    else if (tick)            pre_cnt <= '0;
    else                      pre_cnt <= pre_cnt + DIV_W'(1);
  end
endmodule

// File: rtl/wdt_stage_seq.sv
module wdt_stage_seq
  import wdt_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            feed,
  input  logic                            tick,
  input  logic [NUM_STG-1:0][TMO_W-1:0]   tmo,
  input  logic [NUM_STG-1:0][ACT_W-1:0]   act,
  output logic [SIDX_W-1:0]               stage,
  output logic                            halted,
  output logic                            fire_irq,
  output logic                            fire_cpu,
  output logic                            fire_sys
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] cur_tmo;
  act_e             cur_act;
  logic             expire;
  logic             last_stage;

  assign cur_tmo    = tmo[stage];
  assign cur_act    = act_e'(act[stage]);
  assign last_stage = (stage == SIDX_W'(NUM_STG - 1));
  assign expire     = en && tick && !halted &&
                      (({1'b0, cnt} + (TMO_W+1)'(1)) >= {1'b0, cur_tmo});

  assign fire_irq = expire && (cur_act == ACT_IRQ);
  assign fire_cpu = expire && (cur_act == ACT_CPU);
  assign fire_sys = expire && (cur_act == ACT_SYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= '0;
      cnt    <= '0;
      halted <= 1'b0;
    end else if (!en || feed) begin
      stage  <= '0;
      cnt    <= '0;
      halted <= 1'b0;
    end else if (expire) begin
      cnt <= '0;
      if (cur_act == ACT_OFF || last_stage) halted <= 1'b1;
      else                                   stage  <= stage + SIDX_W'(1);
    end else if (tick && !halted) begin
      cnt <= cnt + TMO_W'(1);
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
  import wdt_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] code,
  output logic          pulse
);
  localparam int LEN_W = (1 << CW) + 1;

  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] load_len;

  assign load_len = LEN_W'(1) << ({1'b0, code} + (CW+1)'(1));
  assign pulse    = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (start)       remain <= load_len;
    else if (pulse)       remain <= remain - LEN_W'(1);
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int TMO_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  input  logic [SIDX_W-1:0]             stage,
  input  logic                          halted,
  input  logic                          fire_irq,
  output logic [CTRL_W-1:0]             ctrl_q,
  output logic [DIV_W-1:0]              div_q,
  output logic [NUM_STG-1:0][TMO_W-1:0] tmo_q,
  output logic                          iena_q,
  output logic                          iraw_q,
  output logic                          feed_pulse,
  output logic                          unlocked
);
  logic [DATA_W-1:0] key_q;
  logic              wr_ok;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  assign unlocked   = (key_q == DATA_W'(UNLOCK_KEY));
  assign wr_ok      = we && unlocked;
  assign feed_pulse = wr_ok && hit(addr, A_FEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         key_q <= '0;
    else if (we && hit(addr, A_KEY))    key_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      iena_q <= 1'b0;
    end else if (wr_ok) begin
      if (hit(addr, A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
      if (hit(addr, A_DIV))  div_q  <= wdata[DIV_W-1:0];
      if (hit(addr, A_IENA)) iena_q <= wdata[0];
    end
  end

  for (genvar g = 0; g < NUM_STG; g++) begin : g_tmo
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tmo_q[g] <= '0;
      else if (wr_ok && hit(addr, A_TMO0 + g)) tmo_q[g] <= wdata[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        iraw_q <= 1'b0;
    else if (fire_irq)                                 iraw_q <= 1'b1;
    else if (wr_ok && hit(addr, A_ICLR) && wdata[0])   iraw_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, A_CTRL))      rdata = DATA_W'(ctrl_q);
    else if (hit(addr, A_DIV))  rdata = DATA_W'(div_q);
    else if (hit(addr, A_KEY))  rdata = DATA_W'(unlocked);
    else if (hit(addr, A_IRAW)) rdata = DATA_W'(iraw_q);
    else if (hit(addr, A_IENA)) rdata = DATA_W'(iena_q);
    else if (hit(addr, A_STAT)) rdata = DATA_W'({halted, stage});
    for (int i = 0; i < NUM_STG; i++) begin
      if (hit(addr, A_TMO0 + i)) rdata = DATA_W'(tmo_q[i]);
    end
  end
endmodule

// File: rtl/wdt_multistage.sv
module wdt_multistage
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int TMO_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_level_o,
  output logic              irq_edge_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  logic [CTRL_W-1:0]             ctrl_q;
  logic [DIV_W-1:0]              div_q;
  logic [NUM_STG-1:0][TMO_W-1:0] tmo_q;
  logic [NUM_STG-1:0][ACT_W-1:0] act_sel;
  logic                          iena_q;
  logic                          iraw_q;
  logic                          feed_pulse;
  logic                          unlocked;
  logic                          tick;
  logic [SIDX_W-1:0]             stage;
  logic                          halted;
  logic                          fire_irq;
  logic                          fire_cpu;
  logic                          fire_sys;
  logic                          en;

  assign en = ctrl_q[C_EN];

  for (genvar s = 0; s < NUM_STG; s++) begin : g_act
    assign act_sel[s] = ctrl_q[C_ACT_LO + ACT_W*s +: ACT_W];
  end

  wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .TMO_W(TMO_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .stage(stage), .halted(halted), .fire_irq(fire_irq),
    .ctrl_q(ctrl_q), .div_q(div_q), .tmo_q(tmo_q),
    .iena_q(iena_q), .iraw_q(iraw_q),
    .feed_pulse(feed_pulse), .unlocked(unlocked)
  );

  wdt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(feed_pulse),
    .div(div_q), .tick(tick)
  );

  wdt_stage_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .feed(feed_pulse), .tick(tick),
    .tmo(tmo_q), .act(act_sel),
    .stage(stage), .halted(halted),
    .fire_irq(fire_irq), .fire_cpu(fire_cpu), .fire_sys(fire_sys)
  );

  wdt_pulse_gen #(.CW(CODE_W)) u_cpu_pulse (
    .clk(clk), .rst_n(rst_n), .start(fire_cpu),
    .code(ctrl_q[C_CPU_LO +: CODE_W]), .pulse(cpu_rst_o)
  );

  wdt_pulse_gen #(.CW(CODE_W)) u_sys_pulse (
    .clk(clk), .rst_n(rst_n), .start(fire_sys),
    .code(ctrl_q[C_SYS_LO +: CODE_W]), .pulse(sys_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_edge_o <= 1'b0;
    else        irq_edge_o <= fire_irq && iena_q && ctrl_q[C_EDGE];
  end

  assign irq_level_o = iraw_q && iena_q && ctrl_q[C_LVL];
endmodule

// File: rtl/wdt_multistage_chk.sv
module wdt_multistage_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              unlocked,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              feed_pulse,
  input logic [SIDX_W-1:0] stage,
  input logic              halted,
  input logic              en,
  input logic              iraw_q,
  input logic              fire_irq,
  input logic              fire_cpu,
  input logic              fire_sys,
  input logic              irq_level_o,
  input logic              irq_edge_o,
  input logic              cpu_rst_o,
  input logic              sys_rst_o
);
  p_locked_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !unlocked && bus_addr == ADDR_W'(A_CTRL)) |=> $stable(ctrl_q));

  p_feed_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    feed_pulse |=> (stage == '0 && !halted));

  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && en && !feed_pulse) |=> ($stable(stage) && halted));

  p_cpu_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_cpu |=> cpu_rst_o);

  p_sys_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_sys |=> sys_rst_o);

  p_raw_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iraw_q && !(bus_we && unlocked && bus_addr == ADDR_W'(A_ICLR) && bus_wdata[0]))
      |=> iraw_q);

  p_level_from_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level_o |-> iraw_q);

  p_edge_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge_o |-> $past(fire_irq));

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (stage == '0 && !halted));
endmodule

bind wdt_multistage wdt_multistage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .unlocked(unlocked), .ctrl_q(ctrl_q),
  .feed_pulse(feed_pulse), .stage(stage), .halted(halted), .en(en),
  .iraw_q(iraw_q), .fire_irq(fire_irq), .fire_cpu(fire_cpu),
  .fire_sys(fire_sys), .irq_level_o(irq_level_o), .irq_edge_o(irq_edge_o),
  .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
);

// File: tb/tb_wdt_multistage.sv
module tb_wdt_multistage;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [31:0] KEYV = 32'hA5C3_0F69;
  localparam int LIMIT = 150000;

  localparam int EV_LVL = 0, EV_EDGE = 1, EV_SYSR = 2, EV_SYSF = 3,
                 EV_CPUR = 4, EV_CPUF = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq_level_o, irq_edge_o, cpu_rst_o, sys_rst_o;

  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  int m_tests = 0, m_fail = 0;

  typedef struct { int kind; int at; } evt_t;
  evt_t exp_q[$];

  wdt_multistage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level_o(irq_level_o), .irq_edge_o(irq_edge_o),
    .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // watchdog
  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_tests + m_tests + 1, n_fail + m_fail + 1);
      $finish;
    end
  end

  // monitor: compares observed output events with the scoreboard queue
  logic p_lvl = 1'b0, p_sys = 1'b0, p_cpu = 1'b0;

  function automatic string ev_req(input int k);
    case (k)
      EV_LVL:  return "R8";
      EV_EDGE: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic mon_seen(input int k);
    evt_t e;
    m_tests++;
    if (exp_q.size() == 0) begin
      m_fail++;
      $display("FAIL %s/R3 unexpected event kind %0d at cycle %0d, expected none", ev_req(k), k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.at != cyc) begin
        m_fail++;
        $display("FAIL %s/R3 event actual kind %0d cycle %0d, expected kind %0d cycle %0d",
                 ev_req(k), k, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_level_o && !p_lvl) mon_seen(EV_LVL);
      if (irq_edge_o)            mon_seen(EV_EDGE);
      if (sys_rst_o && !p_sys)   mon_seen(EV_SYSR);
      if (!sys_rst_o && p_sys)   mon_seen(EV_SYSF);
      if (cpu_rst_o && !p_cpu)   mon_seen(EV_CPUR);
      if (!cpu_rst_o && p_cpu)   mon_seen(EV_CPUF);
    end
    p_lvl = irq_level_o;
    p_sys = sys_rst_o;
    p_cpu = cpu_rst_o;
  end

  // driver helpers
  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, output int edge_at);
    bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    edge_at = cyc;
  endtask

  task automatic wr0(input int a, input logic [31:0] d);
    int unused;
    wr(a, d, unused);
  endtask

  task automatic rd_chk(input int a, input logic [31:0] expv, input string req);
    bus_addr = ADDR_W'(a);
    #1;
    chk(bus_rdata == expv, req, bus_rdata, expv);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_evt(input int k, input int at);
    evt_t e;
    e.kind = k; e.at = at;
    exp_q.push_back(e);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // control word helper: en, lvl, edge, cpu code, sys code, act0..act3
  function automatic logic [31:0] cw(input bit e, input bit l, input bit g,
                                     input int cpu, input int sys,
                                     input int a0, input int a1, input int a2, input int a3);
    return 32'(e) | (32'(l) << 1) | (32'(g) << 2) | (32'(cpu) << 3) | (32'(sys) << 6) |
           (32'(a0) << 9) | (32'(a1) << 11) | (32'(a2) << 13) | (32'(a3) << 15);
  endfunction

  initial begin
    int f, f1, w;
    logic [31:0] cval;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!irq_level_o && !irq_edge_o && !cpu_rst_o && !sys_rst_o, "R11 outputs",
        {irq_level_o, irq_edge_o, cpu_rst_o, sys_rst_o}, 0);
    rd_chk(0, 0, "R11 ctrl");
    rd_chk(7, 0, "R11 locked");
    rd_chk(11, 0, "R11 stat");

    // R1 lock behaviour
    wr0(0, 32'h1);
    rd_chk(0, 0, "R1 locked ctrl write");
    wr0(1, 32'd5);
    rd_chk(1, 0, "R1 locked div write");
    wr0(7, KEYV);
    rd_chk(7, 1, "R1 unlock");
    wr0(1, 32'd4);
    rd_chk(1, 4, "R1 unlocked div write");
    wr0(7, 32'h0);
    wr0(1, 32'd9);
    rd_chk(1, 4, "R1 relocked div write");
    wr0(7, KEYV);

    // scenario A: irq stage then system reset stage, then off stage halts (R3 R4 R6 R7 R8)
    wr0(2, 3); wr0(3, 5); wr0(4, 2); wr0(5, 2);
    wr0(9, 1);
    wr0(0, cw(1, 1, 0, 0, 1, 1, 3, 0, 0));
    wr(6, 32'hDEAD_0001, f);
    expect_evt(EV_LVL, f + 12);
    expect_evt(EV_SYSR, f + 32);
    expect_evt(EV_SYSF, f + 36);
    wait_until(f + 50);
    drained("R4 escalation events");
    rd_chk(11, 6, "R5 halted at off stage 2");
    rd_chk(8, 1, "R7 raw set");
    chk(irq_level_o, "R8 level held", irq_level_o, 1);
    wr0(10, 1);
    chk(!irq_level_o, "R7 level cleared", irq_level_o, 0);
    rd_chk(8, 0, "R7 raw cleared");

    // scenario B: feed mid-stage restarts (R2)
    wr0(0, 0);
    wr0(0, cw(1, 1, 0, 0, 0, 1, 0, 0, 0));
    wr(6, 32'h0, f1);
    wait_until(f1 + 8);
    wr(6, 32'h1234, f);
    expect_evt(EV_LVL, f + 12);
    wait_until(f + 40);
    drained("R2 feed restart");
    rd_chk(11, 5, "R5 halted at off stage 1");
    wr0(10, 1);

    // scenario C: edge only, then level masked (R9 R8)
    wr0(0, 0);
    wr0(0, cw(1, 0, 1, 0, 0, 1, 0, 0, 0));
    wr(6, 32'h0, f);
    expect_evt(EV_EDGE, f + 12);
    wait_until(f + 20);
    drained("R9 edge pulse");
    chk(!irq_level_o, "R9 level stays low", irq_level_o, 0);
    rd_chk(8, 1, "R7 raw set by edge-mode stage");
    wr0(10, 1);
    wr0(9, 0);
    wr0(0, 0);
    wr0(0, cw(1, 1, 0, 0, 0, 1, 0, 0, 0));
    wr(6, 32'h0, f);
    wait_until(f + 16);
    rd_chk(8, 1, "R8 raw set under mask");
    chk(!irq_level_o, "R8 masked level", irq_level_o, 0);
    wr0(10, 1);
    wr0(9, 1);

    // scenario D: off stage 0 halts silently (R5)
    wr0(0, 0);
    wr0(0, cw(1, 1, 0, 0, 0, 0, 1, 1, 1));
    wr(6, 32'h0, f);
    wait_until(f + 40);
    rd_chk(11, 4, "R5 halted at stage 0");
    drained("R5 no action");

    // scenario E: div 0, longest cpu reset (R3 R6)
    wr0(0, 0);
    wr0(1, 0);
    wr0(0, cw(1, 0, 0, 7, 0, 2, 0, 0, 0));
    wr(6, 32'h0, f);
    expect_evt(EV_CPUR, f + 3);
    expect_evt(EV_CPUF, f + 259);
    wait_until(f + 270);
    drained("R6 cpu pulse 256");
    rd_chk(11, 5, "R5 halted after cpu stage");

    // scenario F: disabled stays idle, enable starts, timeout 0 (R10 R3)
    wr0(0, 0);
    wr0(1, 1);
    wr0(0, cw(0, 1, 0, 0, 0, 1, 0, 0, 0));
    wr(6, 32'h0, f);
    wait_until(f + 30);
    rd_chk(11, 0, "R10 disabled stage");
    chk(!irq_level_o, "R10 disabled quiet", irq_level_o, 0);
    wr0(2, 0);
    cval = cw(1, 1, 0, 0, 0, 1, 0, 0, 0);
    wr(0, cval, w);
    expect_evt(EV_LVL, w + 1);
    wait_until(w + 10);
    drained("R10 enable start with timeout 0");
    rd_chk(0, cval, "R4 ctrl readback");
    wr0(10, 1);

    // scenario G: feed while locked is ignored (R1)
    wr0(0, 0);
    wr0(1, 2);
    wr0(2, 5);
    wr(0, cw(1, 1, 0, 0, 0, 1, 0, 0, 0), w);
    wr0(7, 0);
    wait_until(w + 4);
    wr0(6, 32'h0);
    expect_evt(EV_LVL, w + 10);
    wait_until(w + 20);
    drained("R1 locked feed ignored");
    wr0(7, KEYV);
    wr0(10, 1);
    wr0(0, 0);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests + m_tests, n_fail + m_fail);
    $finish;
  end
endmodule